// File: doc/BRIEF.md
# USB End-of-Packet Detector

This block watches the two single-ended receiver outputs of a USB full-speed or low-speed link, sampled by a 48 MHz oversampling clock. It finds where each packet ends. A packet ends when the line holds a single-ended zero (SE0: both wires low) for long enough at the selected link speed and then moves to the idle J state. When that happens the block emits a one-cycle end-of-packet pulse.

A malformed ending is an SE0 that is long enough but is followed by something other than J. This still ends the packet, so that a capture pipeline behind the block can re-arm for the next packet. In that case the block also raises a cautionary bad-ending flag and presents a fixed status code. The 3-bit state register is exported unchanged so that a debug probe can follow the detector sample by sample.

The two wires are first passed through a resynchroniser. The length of the SE0 is counted in sample clocks: 3 samples at full speed and 15 at low speed by default. A speed input chooses which threshold applies to each SE0 run.

Top module: `usb_eop_detector`

## Requirements
- R1: While reset is held, and after it is released with an idle line, `fsm_state` is 000, and `eop_pulse`, `bad_eop` and `status_code` are all zero.
- R2: Line classes are taken from {`line_dp`,`line_dm`}. 00 is SE0. J is 10 at full speed and 01 at low speed. Every other value, including 11, counts as "not J".
- R3: At full speed an SE0 run steps `fsm_state` through 100 (first sample), then 010, then 110 once `FS_SAMPLES` SE0 samples have been seen. The state stays at 110 for as long as SE0 lasts.
- R4: At low speed an SE0 run shows 101 on the first sample and 011 after that. The state stays at 011 for as long as SE0 lasts.
- R5: A J that follows a qualified SE0 run moves the state to 001 for exactly one cycle. `eop_pulse` is high in that cycle only.
- R6: A not-J, non-SE0 value that follows a qualified SE0 run moves the state to 111 for one cycle. `eop_pulse` and `bad_eop` are both high in that cycle.
- R7: `status_code` equals 6'b110111 in the cycle in which `bad_eop` is high, and is zero in every other cycle.
- R8: An SE0 run shorter than the threshold, followed by any non-SE0 value, returns the state to 000 with no pulse.
- R9: The speed in force for a run is the value of `low_speed` when the first SE0 sample reaches the state machine. Later changes to `low_speed` during that run have no effect.
- R10: A line value applied before rising edge k is reflected in `fsm_state` after rising edge k+`SYNC_STAGES`.
- R11: After state 001 or 111 the machine always returns to 000 on the next edge, whatever the line value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_dp | input | 1 | Receiver output for the D+ wire (asynchronous) |
| line_dm | input | 1 | Receiver output for the D- wire (asynchronous) |
| low_speed | input | 1 | 1 selects the low-speed threshold and J polarity for new SE0 runs |
| eop_pulse | output | 1 | One-cycle end-of-packet strobe, for both valid and malformed endings |
| bad_eop | output | 1 | One-cycle flag marking a malformed ending |
| status_code | output | 6 | 110111 during a malformed ending, zero otherwise |
| fsm_state | output | 3 | Raw state encoding, for debug observation |

## Verification
The bound checker watches several properties on every cycle. It checks that the strobe never lasts two cycles and that every ending returns to idle. It checks that the bad flag never appears without the strobe and that the status code tracks the bad flag exactly. It also checks that the qualified-run and ending states are entered only from their legal predecessors. Other behaviour needs a reference model driven by the bench's stimulus. This covers the exact thresholds of 3 and 15 samples and the J polarity at each speed. It also covers the latency through the resynchroniser, runs one sample short of the threshold, and a speed change in the middle of a run.

// File: rtl/usb_eop_pkg.sv
// Package: shared types for the end-of-packet detector.
// The state encodings are exported as-is on a debug port and must not change.
package usb_eop_pkg;

    // Detector states; the encodings are visible to debug tooling.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'b000,
        ST_FS_SE0A = 3'b100,
        ST_FS_SE0B = 3'b010,
        ST_FS_SE0Q = 3'b110,
        ST_END_OK  = 3'b001,
        ST_LS_SE0A = 3'b101,
        ST_LS_SE0Q = 3'b011,
        ST_END_BAD = 3'b111
    } eop_state_t;

    // Raw line class, bit order {dp, dm}.
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_DM  = 2'b01,
        LN_DP  = 2'b10,
        LN_SE1 = 2'b11
    } line_t;

    // Status code shown while a malformed ending is reported.
    localparam logic [5:0] BAD_END_STATUS = 6'b110111;

endpackage

// File: rtl/usb_eop_line_sync.sv
// Module: resynchronises the two asynchronous receiver outputs into the
// sample clock domain and presents them as a line class.
// Assumes STAGES >= 1. On reset the line is taken as idle (D+ high).
module usb_eop_line_sync
    import usb_eop_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dp_i,
    input  logic  dm_i,
    output line_t line_o
);

    localparam int CHAIN_W = 2 * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single register stage captures the wires.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= 2'b10;
                else        chain_q <= {dp_i, dm_i};
            end
        end else begin : g_multi
            // Purpose: shift the wire pair through the resync chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{2'b10}};
                else        chain_q <= {chain_q[CHAIN_W-3:0], dp_i, dm_i};
            end
        end
    endgenerate

    assign line_o = line_t'(chain_q[CHAIN_W-1 -: 2]);

endmodule

// File: rtl/usb_eop_run_counter.sv
// Module: counts consecutive SE0 samples of the run now in progress.
// Saturates at MAX_COUNT. It clears whenever the state machine says the next
// state is not part of an SE0 run.
module usb_eop_run_counter #(
    parameter int MAX_COUNT = 15,
    parameter int CW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_next_i,
    output logic [CW-1:0] count_o
);

    localparam logic [CW-1:0] CAP = CW'(MAX_COUNT);

    // Purpose: count run samples, clear outside a run, hold at the cap.
    always_ff @(posedge clk) begin
        if (!rst_n)           count_o <= '0;
        else if (!run_next_i) count_o <= '0;
        else if (count_o < CAP) count_o <= count_o + 1'b1;
    end

endmodule

// File: rtl/usb_eop_fsm.sv
// Module: end-of-packet state machine.
// It watches SE0 runs, qualifies them against the threshold for the speed
// latched at the start of the run, and classifies the value that follows.
// Assumes FS_SAMPLES >= 3 and LS_SAMPLES >= 2, and that run_cnt_i counts the
// SE0 samples already absorbed in the current run.
module usb_eop_fsm
    import usb_eop_pkg::*;
#(
    parameter int FS_SAMPLES = 3,
    parameter int LS_SAMPLES = 15,
    parameter int CW         = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  line_t         line_i,
    input  logic          low_speed_i,
    input  logic [CW-1:0] run_cnt_i,
    output eop_state_t    state_o,
    output logic          run_next_o
);

    localparam logic [CW-1:0] FS_T = CW'(FS_SAMPLES);
    localparam logic [CW-1:0] LS_T = CW'(LS_SAMPLES);

    eop_state_t    state_q;
    eop_state_t    state_d;
    logic          is_se0;
    logic [CW-1:0] cnt_inc;

    assign is_se0  = (line_i == LN_SE0);
    assign cnt_inc = run_cnt_i + 1'b1;

    // Purpose: next-state decision for one line sample.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_se0) state_d = low_speed_i ? ST_LS_SE0A : ST_FS_SE0A;
            end
            ST_FS_SE0A: begin
                state_d = is_se0 ? ST_FS_SE0B : ST_IDLE;
            end
            ST_FS_SE0B: begin
                if (!is_se0)              state_d = ST_IDLE;
                else if (cnt_inc >= FS_T) state_d = ST_FS_SE0Q;
            end
            ST_FS_SE0Q: begin
                if (!is_se0) state_d = (line_i == LN_DP) ? ST_END_OK : ST_END_BAD;
            end
            ST_LS_SE0A: begin
                state_d = is_se0 ? ST_LS_SE0Q : ST_IDLE;
            end
            ST_LS_SE0Q: begin
                if (!is_se0) begin
                    if (run_cnt_i >= LS_T)
                        state_d = (line_i == LN_DM) ? ST_END_OK : ST_END_BAD;
                    else
                        state_d = ST_IDLE;
                end
            end
            ST_END_OK:  state_d = ST_IDLE;
            ST_END_BAD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Purpose: tell the counter whether the next state continues a run.
    always_comb begin
        unique case (state_d)
            ST_FS_SE0A, ST_FS_SE0B, ST_FS_SE0Q,
            ST_LS_SE0A, ST_LS_SE0Q: run_next_o = 1'b1;
            default:                run_next_o = 1'b0;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/usb_eop_detector.sv
// Module: top level of the USB end-of-packet detector.
// It resynchronises the receiver wires, counts SE0 runs, and drives the
// ending strobe, the bad-ending flag, the status code and the raw state.
// Assumes clk oversamples the full-speed bit rate four times.
module usb_eop_detector
    import usb_eop_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FS_SAMPLES  = 3,
    parameter int LS_SAMPLES  = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_dp,
    input  logic       line_dm,
    input  logic       low_speed,
    output logic       eop_pulse,
    output logic       bad_eop,
    output logic [5:0] status_code,
    output logic [2:0] fsm_state
);

    localparam int MAX_T = (FS_SAMPLES > LS_SAMPLES) ? FS_SAMPLES : LS_SAMPLES;
    localparam int CW    = $clog2(MAX_T + 2);

    line_t         line_s;
    logic [CW-1:0] run_cnt;
    logic          run_next;
    eop_state_t    state;

    usb_eop_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .dp_i   (line_dp),
        .dm_i   (line_dm),
        .line_o (line_s)
    );

    usb_eop_run_counter #(.MAX_COUNT(MAX_T), .CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_next_i (run_next),
        .count_o    (run_cnt)
    );

    usb_eop_fsm #(.FS_SAMPLES(FS_SAMPLES), .LS_SAMPLES(LS_SAMPLES), .CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_s),
        .low_speed_i (low_speed),
        .run_cnt_i   (run_cnt),
        .state_o     (state),
        .run_next_o  (run_next)
    );

    // Purpose: decode the ending outputs from the registered state.
    always_comb begin
        eop_pulse   = (state == ST_END_OK) || (state == ST_END_BAD);
        bad_eop     = (state == ST_END_BAD);
        status_code = (state == ST_END_BAD) ? BAD_END_STATUS : 6'b000000;
    end

    assign fsm_state = state;

endmodule

// File: rtl/usb_eop_detector_chk.sv
// Module: property checker for the end-of-packet detector, bound to the top.
// It sees only the top-level ports.
module usb_eop_detector_chk
    import usb_eop_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] fsm_state,
    input logic       eop_pulse,
    input logic       bad_eop,
    input logic [5:0] status_code
);

    // R5: the strobe never lasts two cycles
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |=> !eop_pulse);

    // R11: every ending returns to idle
    p_end_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |=> (fsm_state == ST_IDLE));

    // R6: the bad flag implies the strobe
    p_bad_has_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_eop |-> eop_pulse);

    // R7: the status code tracks the bad flag
    p_code_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_eop |-> (status_code == 6'b110111));

    p_code_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_eop |-> (status_code == 6'b000000));

    // R3: the qualified full-speed state is entered only from the run states
    p_fs_qual_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_FS_SE0Q) |->
            ($past(fsm_state) == ST_FS_SE0B || $past(fsm_state) == ST_FS_SE0Q));

    // R4: the low-speed run state is entered only from low-speed run states
    p_ls_qual_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_LS_SE0Q) |->
            ($past(fsm_state) == ST_LS_SE0A || $past(fsm_state) == ST_LS_SE0Q));

    // R5: a valid ending follows a qualified run
    p_ok_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_END_OK) |->
            ($past(fsm_state) == ST_FS_SE0Q || $past(fsm_state) == ST_LS_SE0Q));

    // R6: a bad ending follows a qualified run
    p_bad_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_END_BAD) |->
            ($past(fsm_state) == ST_FS_SE0Q || $past(fsm_state) == ST_LS_SE0Q));

endmodule

bind usb_eop_detector usb_eop_detector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsm_state   (fsm_state),
    .eop_pulse   (eop_pulse),
    .bad_eop     (bad_eop),
    .status_code (status_code)
);

// File: tb/usb_eop_detector_test.sv
// Bench: a reference model of the requirements is compared on every cycle,
// and directed threshold cases are run alongside seeded random packets.
module usb_eop_detector_test;

    localparam int CLK_PERIOD = 20;
    localparam int SYNC       = 2;
    localparam int FS_T       = 3;
    localparam int LS_T       = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_dp = 1'b1;
    logic       line_dm = 1'b0;
    logic       low_speed = 1'b0;
    logic       eop_pulse;
    logic       bad_eop;
    logic [5:0] status_code;
    logic [2:0] fsm_state;

    int n_checks = 0;
    int n_fail   = 0;
    int n_eop    = 0;
    int n_bad    = 0;
    logic [5:0] last_bad_code = '0;
    bit   done = 1'b0;
    bit   mon_en = 1'b0;

    usb_eop_detector #(.SYNC_STAGES(SYNC), .FS_SAMPLES(FS_T), .LS_SAMPLES(LS_T)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_dp     (line_dp),
        .line_dm     (line_dm),
        .low_speed   (low_speed),
        .eop_pulse   (eop_pulse),
        .bad_eop     (bad_eop),
        .status_code (status_code),
        .fsm_state   (fsm_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R2: the J value for a given speed
    function automatic logic [1:0] jsym(input bit ls);
        return ls ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] ksym(input bit ls);
        return ls ? 2'b10 : 2'b01;
    endfunction

    // Expected state code from the model variables (R3, R4, R5, R6).
    function automatic logic [2:0] exp_state(input int path, input int run, input int fin);
        if (fin == 1) return 3'b001;
        if (fin == 2) return 3'b111;
        if (path == 0) return 3'b000;
        if (path == 1) return (run == 1) ? 3'b100 : ((run < FS_T) ? 3'b010 : 3'b110);
        return (run == 1) ? 3'b101 : 3'b011;
    endfunction

    task automatic check(input int act, input int exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: a resync delay of SYNC samples, then the run rules.
    logic [1:0] h1, h2;
    int m_path, m_run, m_end;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 <= 2'b10; h2 <= 2'b10;
            m_path <= 0; m_run <= 0; m_end <= 0;
        end else begin
            h1 <= {line_dp, line_dm};
            h2 <= h1;
            if (m_end != 0) begin
                m_end <= 0; m_path <= 0; m_run <= 0;          // R11
            end else if (m_path == 0) begin
                if (h2 == 2'b00) begin
                    m_path <= low_speed ? 2 : 1;              // R9
                    m_run  <= 1;
                end
            end else if (h2 == 2'b00) begin
                if (m_run < 100) m_run <= m_run + 1;
            end else begin
                if (m_run >= ((m_path == 2) ? LS_T : FS_T))
                    m_end <= (h2 == jsym(m_path == 2)) ? 1 : 2;
                m_path <= 0; m_run <= 0;                      // R8
            end
        end
    end

    // Per-cycle comparison, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            check(int'(fsm_state), int'(exp_state(m_path, m_run, m_end)), "R10", "state vs model");
            check(int'(eop_pulse), int'(m_end != 0), "R5", "eop_pulse vs model");
            check(int'(bad_eop), int'(m_end == 2), "R6", "bad_eop vs model");
            check(int'(status_code), (m_end == 2) ? 6'h37 : 0, "R7", "status_code vs model");
            if (eop_pulse) n_eop++;
            if (bad_eop) begin
                n_bad++;
                last_bad_code = status_code;
            end
        end
    end

    task automatic put(input logic [1:0] v);
        {line_dp, line_dm} = v;
        @(negedge clk);
    endtask

    task automatic run_case(input bit ls0, input int n_se0, input logic [1:0] tail,
                            input bit flip_ls, input int exp_e, input int exp_b,
                            input string req);
        int e0, b0;
        e0 = n_eop; b0 = n_bad;
        low_speed = ls0;
        repeat (4) put(jsym(ls0));
        put(ksym(ls0));
        put(jsym(ls0));
        for (int i = 0; i < n_se0; i++) begin
            if (flip_ls && i == 4) low_speed = ~ls0;
            put(2'b00);
        end
        put(tail);
        repeat (6) put(jsym(ls0));
        check(n_eop - e0, exp_e, req, "ending strobes");
        check(n_bad - b0, exp_b, req, "bad endings");
        low_speed = ls0;
    endtask

    task automatic rnd_packet();
        bit ls;
        int nbits, nse0, sel, nidle;
        ls = ($urandom % 4) == 0;
        low_speed = ls;
        nbits = 2 + $urandom % 9;
        for (int i = 0; i < nbits; i++) put(($urandom % 2) ? jsym(ls) : ksym(ls));
        nse0 = 1 + $urandom % 20;
        repeat (nse0) put(2'b00);
        sel = $urandom % 4;
        case (sel)
            0, 3: put(jsym(ls));
            1:    put(ksym(ls));
            default: put(2'b11);
        endcase
        nidle = 1 + $urandom % 4;
        repeat (nidle) put(jsym(ls));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hang expected=completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(int'(fsm_state), 0, "R1", "state in reset");
        check(int'(eop_pulse), 0, "R1", "eop_pulse in reset");
        check(int'(bad_eop), 0, "R1", "bad_eop in reset");
        check(int'(status_code), 0, "R1", "status_code in reset");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(int'(fsm_state), 0, "R1", "state after release");
        mon_en = 1'b1;

        // R10: latency of the resync path
        put(2'b10); put(2'b10); put(2'b10);
        {line_dp, line_dm} = 2'b00;
        @(negedge clk); check(int'(fsm_state), 0, "R10", "after 1 edge");
        @(negedge clk); check(int'(fsm_state), 0, "R10", "after 2 edges");
        @(negedge clk); check(int'(fsm_state), 3'b100, "R10", "after 3 edges");
        repeat (6) put(2'b10);

        // Directed threshold cases
        run_case(1'b0, 3, 2'b10, 1'b0, 1, 0, "R5 fs exact threshold");
        run_case(1'b0, 2, 2'b10, 1'b0, 0, 0, "R8 fs short run");
        run_case(1'b0, 3, 2'b01, 1'b0, 1, 1, "R6 fs K after run");
        check(int'(last_bad_code), 6'h37, "R7", "code during bad ending");
        run_case(1'b0, 5, 2'b11, 1'b0, 1, 1, "R2 fs SE1 after run");
        run_case(1'b1, 15, 2'b01, 1'b0, 1, 0, "R4 ls exact threshold");
        run_case(1'b1, 14, 2'b01, 1'b0, 0, 0, "R8 ls short run");
        run_case(1'b1, 15, 2'b10, 1'b0, 1, 1, "R6 ls K after run");
        run_case(1'b1, 16, 2'b10, 1'b0, 1, 1, "R2 ls with full-speed J");
        run_case(1'b0, 5, 2'b10, 1'b1, 1, 0, "R9 speed change mid-run");

        // R3: long full-speed SE0 holds the qualified state
        low_speed = 1'b0;
        repeat (40) put(2'b00);
        check(int'(fsm_state), 3'b110, "R3", "long SE0 hold");
        repeat (6) put(2'b10);

        // Seeded random packets
        for (int p = 0; p < 1500; p++) rnd_packet();
        repeat (8) put(2'b10);
        finish_run();
    end

endmodule